// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block lets a host read and write a bank of thirty-two byte-wide configuration registers over a four-wire serial link: an active-low select, a serial clock, a data input and a data output. The output is released (its enable is low) whenever it is not carrying read data. Every transaction is one select-framed window of sixteen serial clocks. It carries, in this order, a direction flag, a five-bit register index sent least significant bit first, a guard bit, a spare bit and one data byte, also sent least significant bit first. The whole bank also appears on a wide parallel output so that the rest of the device can use the settings directly.

The serial pins are sampled by the on-chip clock through a short synchronizer. Each serial edge therefore takes effect a fixed number of system clocks after it arrives. Each serial clock phase must last longer than that delay. No part of the link is a stream, so there is no valid/ready handshake. The serial clock paces every transfer and the host cannot be stalled. The parallel register output is plain level state.

Top module: `srs_slave`

## Requirements
- R1: After the asynchronous active-low reset, every register reads 0x00 on `regs_flat` and `sdo_oe` is 0.
- R2: A frame whose first bit is 0 is a write. Bits 2 to 6 carry the index (bit 2 is its LSB) and bits 9 to 16 carry the byte (bit 9 is its LSB). The byte lands in the indexed register once the 16th rising edge has been taken in.
- R3: A frame whose first bit is 1 is a read. `sdo_oe` rises after the 9th rising edge and `sdo` shows bit 0 of the indexed register. Each falling edge of clocks 9 to 15 moves to the next bit, so a host sampling just before falling edges 9 to 16 sees bits 0 to 7 in turn.
- R4: `sdo_oe` stays 0 during the first eight clocks of every frame and whenever `cs_n` is high.
- R5: Frame bit 7 is a guard bit and must be 0. If it is 1, the frame writes nothing and `sdo_oe` stays 0 for the rest of the frame.
- R6: Frame bit 8 is ignored. Frames that differ only in this bit give the same result.
- R7: Raising `cs_n` before the 16th rising edge cancels the frame. No register changes, and `sdo_oe` drops within three system clocks.
- R8: Serial clocks after the 16th in the same frame are ignored. No second write happens and `sdo` keeps showing bit 7.
- R9: A write changes only the indexed register. All other registers keep their value.
- R10: An edge on `sclk` or `cs_n` takes effect on the outputs within SYNC_STAGES+1 system clocks (three by default). For example, `sdo_oe` is 1 three system clocks after the 9th rising edge of a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Frame select, active low |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial read data, valid while `sdo_oe` is 1 |
| sdo_oe | output | 1 | Output enable for the `sdo` pad driver |
| regs_flat | output | 256 | All registers, register n in bits 8n+7 to 8n |

## Verification
A wrong bit count would show up as a shifted read byte on `sdo`, or as an enable that rises one serial clock early or late. The bench samples every serial half-period, so such a fault is caught within one clock of the slip. A corrupted index register or a wrong write strobe shows up on `regs_flat` as soon as the frame closes. That includes a write leaking into another register, or a write let through by an aborted or guarded frame. A stale select or enable shows as `sdo_oe` still high three system clocks after `cs_n` rises.

// File: rtl/srs_pkg.sv
package srs_pkg;
  localparam int ADDR_W    = 5;
  localparam int DATA_W    = 8;
  localparam int NREG      = 1 << ADDR_W;
  localparam int POS_GUARD = 1 + ADDR_W;
  localparam int POS_D0    = POS_GUARD + 2;
  localparam int FRAME_LEN = POS_D0 + DATA_W;
  localparam int CNT_W     = $clog2(FRAME_LEN + 1);

  typedef enum logic [1:0] {PH_CMD, PH_ADDR, PH_GAP, PH_DATA} phase_e;

  function automatic phase_e phase_of(input logic [CNT_W-1:0] c);
    if (int'(c) == 0)              return PH_CMD;
    else if (int'(c) < POS_GUARD)  return PH_ADDR;
    else if (int'(c) < POS_D0)     return PH_GAP;
    else                           return PH_DATA;
  endfunction
endpackage

// File: rtl/srs_sync.sv
module srs_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [STAGES-1:0][W-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[0] <= RST_VAL;
        else        chain[0] <= din;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], din};
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/srs_reg_bank.sv
module srs_reg_bank
  import srs_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic [ADDR_W-1:0]      rd_addr,
  output logic [DATA_W-1:0]      rd_data,
  output logic [NREG*DATA_W-1:0] regs_flat
);
  logic [DATA_W-1:0] mem [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < NREG; i++)
        if (wr_addr == ADDR_W'(i)) mem[i] <= wr_data;
    end
  end

  assign rd_data = mem[rd_addr];

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign regs_flat[g*DATA_W +: DATA_W] = mem[g];

    // R9
    keep_other_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_addr == ADDR_W'(g)) |=> $stable(regs_flat[g*DATA_W +: DATA_W]));
  end
endmodule

// File: rtl/srs_frame_ctrl.sv
module srs_frame_ctrl
  import srs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              sclk_s,
  input  logic              sdi_s,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] reg_addr,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data,
  output logic              sdo,
  output logic              sdo_oe
);
  localparam logic [CNT_W-1:0] C_GUARD = CNT_W'(POS_GUARD);
  localparam logic [CNT_W-1:0] C_D0    = CNT_W'(POS_D0);
  localparam logic [CNT_W-1:0] C_LAST  = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] C_LEN   = CNT_W'(FRAME_LEN);

  logic              sclk_q, rise, fall;
  logic [CNT_W-1:0]  cnt;
  logic              rd_q, bad_q, oe_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] dat_q, out_q;

  assign rise = cs_act &  sclk_s & ~sclk_q;
  assign fall = cs_act & ~sclk_s &  sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      cnt    <= '0;
      rd_q   <= 1'b0;
      bad_q  <= 1'b0;
      oe_q   <= 1'b0;
      addr_q <= '0;
      dat_q  <= '0;
      out_q  <= '0;
    end else begin
      sclk_q <= sclk_s;
      if (!cs_act) begin
        cnt   <= '0;
        oe_q  <= 1'b0;
        bad_q <= 1'b0;
      end else if (rise && cnt < C_LEN) begin
        cnt <= cnt + 1'b1;
        unique case (phase_of(cnt))
          PH_CMD:  rd_q   <= sdi_s;
          PH_ADDR: addr_q <= {sdi_s, addr_q[ADDR_W-1:1]};
          PH_GAP:  if (cnt == C_GUARD) bad_q <= sdi_s;
          PH_DATA: dat_q  <= {sdi_s, dat_q[DATA_W-1:1]};
          default: ;
        endcase
        if (cnt == C_D0 && rd_q && !bad_q) begin
          oe_q  <= 1'b1;
          out_q <= rd_data;
        end
      end else if (fall && oe_q && cnt < C_LEN) begin
        out_q <= out_q >> 1;
      end
    end
  end

  assign wr_en    = rise && cnt == C_LAST && !rd_q && !bad_q;
  assign wr_data  = {sdi_s, dat_q[DATA_W-1:1]};
  assign reg_addr = addr_q;
  assign sdo      = out_q[0];
  assign sdo_oe   = oe_q;

  // R4
  oe_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_q |-> (cnt > C_D0));
  // R7
  cs_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !oe_q);
  // R5
  guard_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_q |-> (!wr_en && !oe_q));
  // R8
  one_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);
endmodule

// File: rtl/srs_slave.sv
module srs_slave
  import srs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cs_n,
  input  logic                   sclk,
  input  logic                   sdi,
  output logic                   sdo,
  output logic                   sdo_oe,
  output logic [NREG*DATA_W-1:0] regs_flat
);
  logic [2:0]        pins_s;
  logic              wr_en;
  logic [ADDR_W-1:0] reg_addr;
  logic [DATA_W-1:0] wr_data, rd_data;

  srs_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({cs_n, sclk, sdi}), .dout(pins_s));

  srs_frame_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_act(~pins_s[2]), .sclk_s(pins_s[1]),
    .sdi_s(pins_s[0]), .rd_data(rd_data), .reg_addr(reg_addr),
    .wr_en(wr_en), .wr_data(wr_data), .sdo(sdo), .sdo_oe(sdo_oe));

  srs_reg_bank u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(reg_addr),
    .wr_data(wr_data), .rd_addr(reg_addr), .rd_data(rd_data),
    .regs_flat(regs_flat));
endmodule

// File: tb/tb_srs_slave.sv
module tb_srs_slave;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;
  localparam int LAT = 3;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  wire sdo, sdo_oe;
  wire [255:0] regs_flat;
  int n_chk = 0, n_err = 0;
  logic [7:0] mdl [32];

  srs_slave dut (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
                 .sdo(sdo), .sdo_oe(sdo_oe), .regs_flat(regs_flat));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [255:0] mdl_flat();
    logic [255:0] v;
    for (int i = 0; i < 32; i++) v[i*8 +: 8] = mdl[i];
    return v;
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // checks sdo_oe and sdo against expectation for a given bit index
  task automatic chk_out(input bit oe_exp, input int idx, input logic [7:0] rb);
    int k;
    k = (idx > 7) ? 7 : idx;
    chk(oe_exp ? "R3 oe" : "R4 oe", sdo_oe, oe_exp);
    if (oe_exp) chk("R3 sdo", sdo, rb[k]);
  endtask

  task automatic frame(input string tag, input bit rd, input int addr, input bit g,
                       input bit sp, input logic [7:0] wd, input int stop_at, input int extra);
    logic [15:0] b;
    bit rv;
    logic [7:0] rb;
    b[0] = rd; b[5:1] = 5'(addr); b[6] = g; b[7] = sp; b[15:8] = wd;
    rv = rd && !g;
    rb = mdl[addr];
    cs_n = 1'b0;
    wait_clk(HALF);
    for (int c = 1; c <= stop_at + extra; c++) begin
      sdi = (c <= 16) ? b[c-1] : c[0];
      wait_clk(HALF);
      chk_out(rv && c >= 10, c - 9, rb);
      sclk = 1'b1;
      if (c == 9 && rv) begin
        wait_clk(LAT);
        chk("R10 oe latency", sdo_oe, 1'b1);
        wait_clk(HALF - LAT);
      end else begin
        wait_clk(HALF);
      end
      chk_out(rv && c >= 9, c - 9, rb);
      sclk = 1'b0;
    end
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(LAT);
    chk({tag, " R7 oe after cs"}, sdo_oe, 1'b0);
    if (!rd && !g && stop_at == 16) mdl[addr] = wd;
    wait_clk(HALF);
    chk({tag, " regs"}, regs_flat, mdl_flat());
  endtask

  initial begin
    #(200000 * CLK_PERIOD);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) mdl[i] = 8'h00;
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(2);
    chk("R1 regs", regs_flat, '0);
    chk("R1 oe", sdo_oe, 1'b0);
    // writes (R2, R9)
    frame("R2", 1'b0, 0,  1'b0, 1'b0, 8'hA5, 16, 0);
    frame("R2", 1'b0, 31, 1'b0, 1'b0, 8'h3C, 16, 0);
    frame("R9", 1'b0, 18, 1'b0, 1'b0, 8'h81, 16, 0);
    // reads (R3)
    frame("R3", 1'b1, 31, 1'b0, 1'b0, 8'h00, 16, 0);
    frame("R3", 1'b1, 18, 1'b0, 1'b0, 8'hFF, 16, 0);
    frame("R3", 1'b1, 9,  1'b0, 1'b0, 8'h00, 16, 0);
    // spare bit ignored (R6)
    frame("R6", 1'b0, 5,  1'b0, 1'b1, 8'h77, 16, 0);
    frame("R6", 1'b1, 5,  1'b0, 1'b1, 8'h00, 16, 0);
    frame("R6", 1'b1, 0,  1'b0, 1'b1, 8'h00, 16, 0);
    // guard bit set (R5)
    frame("R5", 1'b0, 5,  1'b1, 1'b0, 8'h00, 16, 0);
    frame("R5", 1'b1, 31, 1'b1, 1'b0, 8'h00, 16, 0);
    // aborted frames (R7)
    frame("R7", 1'b0, 0,  1'b0, 1'b0, 8'h11, 12, 0);
    frame("R7", 1'b0, 0,  1'b0, 1'b0, 8'h22, 15, 0);
    frame("R7", 1'b1, 31, 1'b0, 1'b0, 8'h00, 12, 0);
    // surplus clocks (R8)
    frame("R8", 1'b0, 7,  1'b0, 1'b0, 8'h5A, 16, 3);
    frame("R8", 1'b1, 7,  1'b0, 1'b0, 8'h00, 16, 2);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule